// File: doc/BRIEF.md
# Finite-Field Register Execution Unit

The unit carries out one finite-field instruction at a time on a small file of wide registers. Each register holds a field element together with a presence bit, so a register may also be empty. Two status flags are kept. The condition flag records the result of the latest test-type instruction. The check flag is a sticky error indicator that collects every failed arithmetic precondition until reset.

A host presents a decoded opcode, two register indices, an immediate field element, a 2-bit constant selector and a 3-bit width code, then pulses `start`. The field modulus is a static input. All instructions except a multiply with two present operands finish in a single cycle. That multiply runs an MSB-first double-and-add loop, with modular reduction at every step, and takes `WIDTH + 1` cycles. A separate combinational read port exposes any register for observation. `WIDTH` must be larger than 128, because two of the preset constants are 64-bit and 128-bit all-ones values. All register values and the modulus are taken to be below 2^WIDTH, and operands are taken to be below the modulus.

Top module: `ffx_unit`

## Requirements
- R1: On reset every register is empty, `co_ok` and `ck_ok` are 1 (1 means ok, 0 means fail), and `done` and `busy` are 0.
- R2: Test (opcode 0) sets `co_ok` to the presence bit of register `src_idx` and leaves `ck_ok` unchanged.
- R3: Clear (1) empties `dst_idx`. Put-immediate (2) writes `imm_value`. Put-zero (3) writes 0. Put-constant (4) writes a preset. Move (6) copies `src_idx` to `dst_idx`, and an empty source makes the destination empty. The move source is never altered. None of these five changes `co_ok` or `ck_ok`.
- R4: The put-constant selector `const_sel` chooses the written value: 0 gives 1, 1 gives 2^64−1, 2 gives 2^128−1, 3 gives `field_order`−1.
- R5: Fits (5) maps `width_sel` 0..7 to 8, 16, 24, 32, 48, 64, 96 and 128 bits. It sets `co_ok` to 1 when the present source value is below 2^bits and to 0 otherwise, and leaves `ck_ok` unchanged.
- R6: Fits on an empty source clears both `co_ok` and `ck_ok`.
- R7: Equality (7) sets `co_ok` to 1 when `dst_idx` and `src_idx` are both empty or both present with equal values, and to 0 otherwise. When both are empty it also clears `ck_ok`.
- R8: Negate (8) writes (`field_order` − src) mod `field_order` to `dst_idx` and leaves `co_ok` unchanged.
- R9: Add (9) writes (dst + src) mod `field_order` to `dst_idx` and leaves `co_ok` unchanged.
- R10: Multiply (10) with two present operands writes (dst × src) mod `field_order` to `dst_idx`. `busy` is 1 for the run, and `done` rises for exactly one cycle `WIDTH + 1` clock edges after the start edge. `co_ok` is unchanged.
- R11: Negate with an empty source, or add or multiply with an empty operand, clears `ck_ok`, writes nothing and completes in one cycle.
- R12: No instruction sets `ck_ok` back to 1; only reset does.
- R13: A `start` that arrives while `busy` is 1 is ignored and alters no register and no flag.
- R14: Every instruction other than a running multiply raises `done` for one cycle after the start edge. Opcodes 11 to 15 complete with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction strobe |
| opcode | input | 4 | Decoded instruction code |
| dst_idx | input | log2(NREGS) | Destination / first source register |
| src_idx | input | log2(NREGS) | Second source register |
| imm_value | input | WIDTH | Immediate field element |
| const_sel | input | 2 | Preset constant selector |
| width_sel | input | 3 | Fits width code |
| field_order | input | WIDTH | Field modulus |
| rd_idx | input | log2(NREGS) | Observation read index |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Multiply in progress |
| co_ok | output | 1 | Condition flag, 1 = ok |
| ck_ok | output | 1 | Sticky check flag, 1 = ok |
| rd_valid | output | 1 | Presence bit of register `rd_idx` |
| rd_data | output | WIDTH | Value of register `rd_idx` |

## Verification
The assertions watch properties that hold on every cycle. The check flag never returns to ok. Both flags stay frozen while a multiply runs. The multiply accumulator stays below the modulus. `done` accompanies the end of `busy`. A clear empties its target. A fits on an empty source drops both flags. A test leaves the check flag alone. The arithmetic results can only be shown by the bench's scenarios, which compare against a wide-integer model. So can the exact multiply latency, the preset constants, the fits boundaries, equality with empty operands and the start that is ignored while busy.

// File: rtl/ffx_pkg.sv
package ffx_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned CSEL_W = 2;
  localparam int unsigned WSEL_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_TEST = 4'd0,
    OP_CLR  = 4'd1,
    OP_PUTD = 4'd2,
    OP_PUTZ = 4'd3,
    OP_PUTC = 4'd4,
    OP_FITS = 4'd5,
    OP_MOV  = 4'd6,
    OP_EQ   = 4'd7,
    OP_NEG  = 4'd8,
    OP_ADD  = 4'd9,
    OP_MUL  = 4'd10
  } ffx_op_e;

  // width code -> number of bits a value must fit into
  function automatic int unsigned fits_bits(logic [WSEL_W-1:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 24;
      3'd3:    return 32;
      3'd4:    return 48;
      3'd5:    return 64;
      3'd6:    return 96;
      default: return 128;
    endcase
  endfunction

endpackage

// File: rtl/ffx_regfile.sv
module ffx_regfile #(
  parameter int unsigned WIDTH = 256,
  parameter int unsigned NREGS = 4,
  localparam int unsigned IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [WIDTH-1:0] a_data,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [WIDTH-1:0] b_data,
  input  logic [IDX_W-1:0] c_idx,
  output logic             c_valid,
  output logic [WIDTH-1:0] c_data
);

  logic             valid_q [NREGS];
  logic [WIDTH-1:0] data_q  [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        valid_q[i] <= 1'b0;
        data_q[i]  <= '0;
      end
    end else if (we) begin
      for (int i = 0; i < NREGS; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          valid_q[i] <= wr_valid;
          if (wr_valid) data_q[i] <= wr_data;
        end
      end
    end
  end

  assign a_valid = valid_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_data  = data_q[b_idx];
  assign c_valid = valid_q[c_idx];
  assign c_data  = data_q[c_idx];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_valid) |=> !valid_q[$past(wr_idx)]); // R3

endmodule

// File: rtl/ffx_alu.sv
module ffx_alu
  import ffx_pkg::*;
#(
  parameter int unsigned WIDTH = 256
) (
  input  logic [WIDTH-1:0]  modulus,
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [CSEL_W-1:0] csel,
  input  logic [WSEL_W-1:0] wsel,
  output logic [WIDTH-1:0]  sum,
  output logic [WIDTH-1:0]  negb,
  output logic [WIDTH-1:0]  cval,
  output logic              fits_ok
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] mod_add(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                                               logic [WIDTH-1:0] m);
    logic [WIDTH:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, m}) s = s - {1'b0, m};
    return s[WIDTH-1:0];
  endfunction

  function automatic logic [WIDTH-1:0] mod_neg(logic [WIDTH-1:0] x, logic [WIDTH-1:0] m);
    return (x == '0) ? '0 : m - x;
  endfunction

  function automatic logic [WIDTH-1:0] preset(logic [CSEL_W-1:0] sel, logic [WIDTH-1:0] m);
    case (sel)
      2'd0:    return WIDTH'(1);
      2'd1:    return ALL_ONES >> (WIDTH - 64);
      2'd2:    return ALL_ONES >> (WIDTH - 128);
      default: return m - WIDTH'(1);
    endcase
  endfunction

  always_comb begin
    sum     = mod_add(opa, opb, modulus);
    negb    = mod_neg(opb, modulus);
    cval    = preset(csel, modulus);
    fits_ok = ((opb >> fits_bits(wsel)) == '0);
  end

endmodule

// File: rtl/ffx_mulloop.sv
module ffx_mulloop #(
  parameter int unsigned WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] modulus,
  output logic             running,
  output logic             last,
  output logic [WIDTH-1:0] product
);

  localparam int unsigned CNT_W = $clog2(WIDTH + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] acc_q, mcand_q, mplier_q;
  logic [WIDTH-1:0] dbl, acc_nxt;

  function automatic logic [WIDTH-1:0] mod_add(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                                               logic [WIDTH-1:0] m);
    logic [WIDTH:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, m}) s = s - {1'b0, m};
    return s[WIDTH-1:0];
  endfunction

  // one double-and-add step, MSB of the multiplier first
  always_comb begin
    dbl     = mod_add(acc_q, acc_q, modulus);
    acc_nxt = mplier_q[WIDTH-1] ? mod_add(dbl, mcand_q, modulus) : dbl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (go) begin
      run_q    <= 1'b1;
      cnt_q    <= CNT_W'(WIDTH);
      acc_q    <= '0;
      mcand_q  <= op_a;
      mplier_q <= op_b;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        acc_q    <= acc_nxt;
        mplier_q <= mplier_q << 1;
        cnt_q    <= cnt_q - CNT_W'(1);
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign running = run_q;
  assign last    = run_q && (cnt_q == '0);
  assign product = acc_q;

  AST_MUL_ACC_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (acc_q < modulus)); // R10

  AST_MUL_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q); // R13

endmodule

// File: rtl/ffx_unit.sv
module ffx_unit
  import ffx_pkg::*;
#(
  parameter int unsigned WIDTH = 256,
  parameter int unsigned NREGS = 4,
  localparam int unsigned IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [WIDTH-1:0]  imm_value,
  input  logic [CSEL_W-1:0] const_sel,
  input  logic [WSEL_W-1:0] width_sel,
  input  logic [WIDTH-1:0]  field_order,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              done,
  output logic              busy,
  output logic              co_ok,
  output logic              ck_ok,
  output logic              rd_valid,
  output logic [WIDTH-1:0]  rd_data
);

  ffx_op_e op;
  assign op = ffx_op_e'(opcode);

  // register file ports
  logic             a_valid, b_valid;
  logic [WIDTH-1:0] a_data, b_data;
  logic             we, wr_valid;
  logic [IDX_W-1:0] wr_idx;
  logic [WIDTH-1:0] wr_data;

  // datapath results
  logic [WIDTH-1:0] sum, negb, cval, product;
  logic             fits_ok;

  // named internal events
  logic accept, mul_go, mul_run, mul_last;
  logic co_set, co_val, ck_fail, done_now;

  logic             co_q, ck_q, done_q;
  logic [IDX_W-1:0] mul_dst_q;

  ffx_regfile #(.WIDTH(WIDTH), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(we), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_data(wr_data),
    .a_idx(dst_idx), .a_valid(a_valid), .a_data(a_data),
    .b_idx(src_idx), .b_valid(b_valid), .b_data(b_data),
    .c_idx(rd_idx),  .c_valid(rd_valid), .c_data(rd_data)
  );

  ffx_alu #(.WIDTH(WIDTH)) u_alu (
    .modulus(field_order), .opa(a_data), .opb(b_data),
    .csel(const_sel), .wsel(width_sel),
    .sum(sum), .negb(negb), .cval(cval), .fits_ok(fits_ok)
  );

  ffx_mulloop #(.WIDTH(WIDTH)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go),
    .op_a(a_data), .op_b(b_data), .modulus(field_order),
    .running(mul_run), .last(mul_last), .product(product)
  );

  assign accept = start && !mul_run;

  always_comb begin
    we       = 1'b0;
    wr_idx   = dst_idx;
    wr_valid = 1'b0;
    wr_data  = '0;
    co_set   = 1'b0;
    co_val   = 1'b0;
    ck_fail  = 1'b0;
    mul_go   = 1'b0;
    done_now = 1'b0;
    if (mul_last) begin
      we       = 1'b1;
      wr_idx   = mul_dst_q;
      wr_valid = 1'b1;
      wr_data  = product;
      done_now = 1'b1;
    end else if (accept) begin
      done_now = 1'b1;
      case (op)
        OP_TEST: begin
          co_set = 1'b1;
          co_val = b_valid;
        end
        OP_CLR: we = 1'b1;
        OP_PUTD: begin
          we = 1'b1; wr_valid = 1'b1; wr_data = imm_value;
        end
        OP_PUTZ: begin
          we = 1'b1; wr_valid = 1'b1;
        end
        OP_PUTC: begin
          we = 1'b1; wr_valid = 1'b1; wr_data = cval;
        end
        OP_FITS: begin
          co_set = 1'b1;
          co_val = b_valid && fits_ok;
          ck_fail = !b_valid;
        end
        OP_MOV: begin
          we = 1'b1; wr_valid = b_valid; wr_data = b_data;
        end
        OP_EQ: begin
          co_set  = 1'b1;
          co_val  = (a_valid == b_valid) && (!a_valid || (a_data == b_data));
          ck_fail = !a_valid && !b_valid;
        end
        OP_NEG: begin
          if (!b_valid) ck_fail = 1'b1;
          else begin
            we = 1'b1; wr_valid = 1'b1; wr_data = negb;
          end
        end
        OP_ADD: begin
          if (!a_valid || !b_valid) ck_fail = 1'b1;
          else begin
            we = 1'b1; wr_valid = 1'b1; wr_data = sum;
          end
        end
        OP_MUL: begin
          if (!a_valid || !b_valid) ck_fail = 1'b1;
          else begin
            mul_go   = 1'b1;
            done_now = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co_q      <= 1'b1;
      ck_q      <= 1'b1;
      done_q    <= 1'b0;
      mul_dst_q <= '0;
    end else begin
      done_q <= done_now;
      ck_q   <= ck_q && !ck_fail;
      if (co_set) co_q <= co_val;
      if (mul_go) mul_dst_q <= dst_idx;
    end
  end

  assign done  = done_q;
  assign busy  = mul_run;
  assign co_ok = co_q;
  assign ck_ok = ck_q;

  AST_CK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_q |=> !ck_q); // R12

  AST_BUSY_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mul_run |=> ($stable(co_q) && $stable(ck_q))); // R13

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mul_run) |-> done_q); // R10

  AST_FITS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_FITS && !b_valid) |=> (!co_q && !ck_q)); // R6

  AST_TEST_KEEPS_CK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_TEST) |=> (ck_q == $past(ck_q))); // R2

endmodule

// File: tb/ffx_unit_bench.sv
module ffx_unit_bench;

  localparam int WIDTH = 256;
  localparam int NREGS = 4;
  localparam int IDX_W = 2;
  localparam time CLK_PERIOD = 10;

  typedef logic [WIDTH-1:0] fe_t;
  localparam fe_t MODULUS = (fe_t'(1) << 255) - fe_t'(19);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] opcode = '0;
  logic [IDX_W-1:0] dst_idx = '0, src_idx = '0, rd_idx = '0;
  fe_t imm_value = '0;
  logic [1:0] const_sel = '0;
  logic [2:0] width_sel = '0;
  logic done, busy, co_ok, ck_ok, rd_valid;
  fe_t rd_data;

  int checks = 0;
  int errors = 0;
  bit over = 0;

  bit  mv [NREGS];
  fe_t md [NREGS];
  bit  mco, mck;

  always #(CLK_PERIOD/2) clk = ~clk;

  ffx_unit #(.WIDTH(WIDTH), .NREGS(NREGS)) u_ffx_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .dst_idx(dst_idx), .src_idx(src_idx), .imm_value(imm_value),
    .const_sel(const_sel), .width_sel(width_sel), .field_order(MODULUS),
    .rd_idx(rd_idx), .done(done), .busy(busy), .co_ok(co_ok), .ck_ok(ck_ok),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(bit ok, string req, fe_t act, fe_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic fe_t b_rand();
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH/32; i++) r[i*32 +: 32] = $urandom;
    return r % MODULUS;
  endfunction

  function automatic fe_t b_add(fe_t a, fe_t b);
    logic [WIDTH:0] s;
    s = ({1'b0, a} + {1'b0, b}) % {1'b0, MODULUS};
    return s[WIDTH-1:0];
  endfunction

  function automatic fe_t b_mul(fe_t a, fe_t b);
    logic [2*WIDTH-1:0] p;
    p = ({{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b}) % {{WIDTH{1'b0}}, MODULUS};
    return p[WIDTH-1:0];
  endfunction

  function automatic fe_t b_neg(fe_t a);
    return (MODULUS - a) % MODULUS;
  endfunction

  function automatic fe_t b_const(int c);
    case (c)
      0: return fe_t'(1);
      1: return (fe_t'(1) << 64) - fe_t'(1);
      2: return (fe_t'(1) << 128) - fe_t'(1);
      default: return MODULUS - fe_t'(1);
    endcase
  endfunction

  function automatic bit b_fits(fe_t v, int code);
    int bits [8] = '{8, 16, 24, 32, 48, 64, 96, 128};
    logic [WIDTH:0] lim;
    lim = {1'b0, fe_t'(1)} << bits[code];
    return {1'b0, v} < lim;
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R2";
      1, 2, 3, 6: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R10";
      default: return "R14";
    endcase
  endfunction

  task automatic check_reg(int idx, string req);
    rd_idx = IDX_W'(idx);
    #1;
    check(rd_valid == mv[idx], req, fe_t'(rd_valid), fe_t'(mv[idx]));
    if (mv[idx]) check(rd_data == md[idx], req, rd_data, md[idx]);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NREGS; i++) begin
      mv[i] = 1'b0;
      md[i] = '0;
    end
    mco = 1'b1;
    mck = 1'b1;
    @(negedge clk);
  endtask

  // called at a negedge; returns at a negedge after the instruction completed
  task automatic do_op(int op, int dst, int src, fe_t imm = '0, int csel = 0,
                       int wsel = 0, bit interfere = 0);
    bit  e_we = 0, e_v = 0, is_long = 0, empty_err = 0;
    fe_t e_d = '0;
    string rq;
    int other;
    rq = req_of(op);
    case (op)
      0: mco = mv[src];
      1: begin e_we = 1; e_v = 0; end
      2: begin e_we = 1; e_v = 1; e_d = imm; end
      3: begin e_we = 1; e_v = 1; e_d = '0; end
      4: begin e_we = 1; e_v = 1; e_d = b_const(csel); end
      5: begin
        if (!mv[src]) begin mco = 0; mck = 0; rq = "R6"; end
        else mco = b_fits(md[src], wsel);
      end
      6: begin e_we = 1; e_v = mv[src]; e_d = md[src]; end
      7: begin
        mco = (mv[dst] == mv[src]) && (!mv[dst] || md[dst] == md[src]);
        if (!mv[dst] && !mv[src]) mck = 0;
      end
      8: begin
        if (!mv[src]) begin mck = 0; empty_err = 1; end
        else begin e_we = 1; e_v = 1; e_d = b_neg(md[src]); end
      end
      9, 10: begin
        if (!mv[dst] || !mv[src]) begin mck = 0; empty_err = 1; end
        else begin
          e_we = 1; e_v = 1;
          e_d = (op == 9) ? b_add(md[dst], md[src]) : b_mul(md[dst], md[src]);
          is_long = (op == 10);
        end
      end
      default: ;
    endcase
    if (empty_err) rq = "R11";

    opcode = 4'(op);
    dst_idx = IDX_W'(dst);
    src_idx = IDX_W'(src);
    imm_value = imm;
    const_sel = 2'(csel);
    width_sel = 3'(wsel);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    other = (dst + 1) % NREGS;
    if (is_long) begin
      check(done == 1'b0 && busy == 1'b1, "R10", fe_t'({done, busy}), fe_t'(2'b01));
      if (interfere) begin
        opcode = 4'd1;
        dst_idx = IDX_W'(other);
        start = 1'b1;
      end
      for (int k = 0; k < WIDTH; k++) begin
        @(negedge clk);
        start = 1'b0;
        if (done) check(1'b0, "R10", fe_t'(done), '0);
      end
      @(negedge clk);
      check(done == 1'b1, "R10", fe_t'(done), fe_t'(1));
    end else begin
      check(done == 1'b1, empty_err ? "R11" : "R14", fe_t'(done), fe_t'(1));
    end
    if (e_we) begin
      mv[dst] = e_v;
      if (e_v) md[dst] = e_d;
    end
    check(co_ok == mco, rq, fe_t'(co_ok), fe_t'(mco));
    check(ck_ok == mck, (op == 5 && rq == "R6") ? "R6" : "R12", fe_t'(ck_ok), fe_t'(mck));
    check_reg(dst, rq);
    check_reg(src, rq);
    if (interfere) check_reg(other, "R13");
    @(negedge clk);
    check(done == 1'b0, "R14", fe_t'(done), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!over) begin
      checks++;
      errors++;
      $display("FAIL R14 watchdog actual=hung expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    reset_dut();
    // R1: reset state
    check(done == 0 && busy == 0, "R1", fe_t'({done, busy}), '0);
    check(co_ok == 1 && ck_ok == 1, "R1", fe_t'({co_ok, ck_ok}), fe_t'(2'b11));
    for (int i = 0; i < NREGS; i++) check_reg(i, "R1");

    // R7: two empty registers compare equal and raise the check error
    do_op(7, 0, 1);
    reset_dut();

    // R4: every preset constant
    for (int c = 0; c < 4; c++) do_op(4, c, c, '0, c);

    // R5: fits boundaries
    do_op(2, 0, 0, fe_t'(255));
    do_op(5, 1, 0, '0, 0, 0);
    do_op(2, 0, 0, fe_t'(256));
    do_op(5, 1, 0, '0, 0, 0);
    do_op(2, 1, 1, (fe_t'(1) << 128) - 1);
    do_op(5, 0, 1, '0, 0, 7);
    do_op(5, 0, 1, '0, 0, 6);
    do_op(2, 1, 1, fe_t'(1) << 128);
    do_op(5, 0, 1, '0, 0, 7);
    do_op(2, 1, 1, (fe_t'(1) << 96) - 1);
    do_op(5, 0, 1, '0, 0, 6);
    // R6: fits on an empty source
    do_op(1, 2, 2);
    do_op(5, 0, 2, '0, 0, 3);
    reset_dut();

    // R9 / R8 / R10 / R13 wraparound corners
    do_op(2, 0, 0, MODULUS - 1);
    do_op(2, 1, 1, fe_t'(1));
    do_op(9, 0, 1);
    do_op(8, 2, 0);
    do_op(4, 3, 3, '0, 3);
    do_op(10, 3, 3, '0, 0, 0, 1);
    do_op(2, 1, 1, b_rand());
    do_op(10, 1, 3);
    // R3: move from an empty source empties the destination
    do_op(1, 2, 2);
    do_op(6, 1, 2);
    // R11: empty operands
    do_op(8, 0, 2);
    do_op(9, 2, 0);
    do_op(10, 0, 2);

    // constrained random segments
    for (int seg = 0; seg < 5; seg++) begin
      reset_dut();
      for (int n = 0; n < 60; n++) begin
        int op, d, s, sel;
        fe_t imm;
        op = $urandom_range(0, 12);
        d = $urandom_range(0, NREGS - 1);
        s = $urandom_range(0, NREGS - 1);
        sel = $urandom_range(0, 3);
        case (sel)
          0: imm = fe_t'($urandom_range(0, 300));
          1: imm = MODULUS - 1;
          2: imm = (fe_t'(1) << (8 * $urandom_range(1, 16))) - fe_t'($urandom_range(0, 1));
          default: imm = b_rand();
        endcase
        if (n < 4) op = 2;
        do_op(op, d, s, imm, $urandom_range(0, 3), $urandom_range(0, 7),
              (op == 10) && ($urandom_range(0, 1) == 1));
      end
    end

    over = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule